// File: doc/BRIEF.md
# Flash Program and Erase Sequencer

This block owns the 8-bit control register of an on-chip flash array. It also runs the timed high-voltage steps that program a page or erase a block. Software can write the register directly. The block applies hardware interlocks to every write, so the program, erase, high-voltage and margin bits can never reach an unsafe combination.

For a complete operation the block takes a single command:
- A program command carries a page address and eight data bytes. The block loads the page, applies a high-voltage pulse and then verifies each byte with a stretched margin read. It repeats the pulse until the data matches or the pulse budget runs out.
- An erase command carries an address and a block-size code. The block arms erase, touches the block, applies one long pulse and waits for discharge and recovery.

All waits are counted in ticks of a pump clock enable. The enable is the bus clock divided by a power of two chosen in the register.

Top module: `nvm_pe_ctrl`

## Requirements
- R1: After synchronous reset the control register reads 0x00, and `busy`, `done` and `fail` are low.
- R2: The register layout from bit 7 down to bit 0 is: divide select (2 bits), block select (2 bits), HVEN, MARGIN, ERASE, PGM. Any write with both bit 1 and bit 0 set is rejected, and the register keeps its old value.
- R3: A write sets bit 3 (HVEN) only if bit 0 or bit 1 was already 1 before that write; otherwise bit 3 reads 0.
- R4: A write sets bit 2 (MARGIN) only if the resulting HVEN is 0 and bit 0 or bit 2 was already 1. When HVEN is 1, MARGIN always reads 0.
- R5: With divide select d (bits 7:6), `pump_en` pulses exactly once every 2^d bus cycles while idle.
- R6: A program command issues eight array writes to addresses {cmd_addr[AW-1:3], i} for i = 0..7, with byte i taken from page_data[8i+7:8i]. The low three address bits are ignored.
- R7: During programming, MARGIN rises only while PGM is 1 and HVEN is 0. Every margin read happens with MARGIN at 1 and PGM at 0.
- R8: Each program pulse holds `arr_hv` high for exactly T_PROG·2^d + 1 bus cycles.
- R9: Each of the eight verify reads holds `arr_rd` on one address for 1 + MARGIN_EXTRA cycles, so one verify pass lasts 8·(1+MARGIN_EXTRA) read cycles.
- R10: Program pulses repeat until the margin-read data equals the written data. The number of pulses then equals the number the array needed, and `done` pulses with `fail` low.
- R11: If the data still differs after MAX_PULSES pulses, `done` pulses with `fail` high and no further pulse is applied.
- R12: An erase command performs these steps in order:
  - one array write at cmd_addr, with ERASE at 1 and the block bits equal to cmd_blk;
  - one pulse of T_ERASE·2^d + 1 cycles;
  - at `done`, the register reads back the divide and block fields with the low four bits at 0.
- R13: While `busy` is high, register writes and new commands have no effect; the divide select is preserved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write value |
| reg_rdata | output | 8 | Current control register |
| cmd_prog | input | 1 | Start a page program (idle only) |
| cmd_erase | input | 1 | Start a block erase (idle only) |
| cmd_addr | input | AW | Target address |
| cmd_blk | input | 2 | Erase block-size code |
| page_data | input | 64 | Eight page bytes, byte 0 in the low bits |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |
| fail | output | 1 | Valid with done: program gave up |
| pump_en | output | 1 | Pump clock enable |
| arr_wr | output | 1 | Array latch write |
| arr_rd | output | 1 | Array read (margin verify) |
| arr_addr | output | AW | Array address |
| arr_wdata | output | 8 | Array write data |
| arr_rdata | input | 8 | Array read data |
| arr_prog | output | 1 | Program mode (PGM bit) |
| arr_erase | output | 1 | Erase mode (ERASE bit) |
| arr_hv | output | 1 | High voltage on (HVEN bit) |
| arr_margin | output | 1 | Margin read mode (MARGIN bit) |
| arr_blk | output | 2 | Block-size code to the array |

## Verification
The assertions assume that the array answers a read combinationally from `arr_addr` and that the divide select is not rewritten on the same cycle a pump tick is due. The bench changes the divide field only through ordinary register writes while idle. It models the array so that read data depends only on the address and on the pulses counted so far.

They also assume that commands arrive only in a clean state. The bench sweeps every write value from five reachable register states, and each sequence it starts runs from a register whose low four bits are zero.

// File: rtl/nvm_pe_pkg.sv
package nvm_pe_pkg;

    typedef struct packed {
        logic [1:0] fdiv;
        logic [1:0] blk;
        logic       hven;
        logic       margin;
        logic       erase;
        logic       pgm;
    } ctl_t;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_P_PGM,
        ST_P_LOAD,
        ST_P_HVON,
        ST_P_HVOFF,
        ST_P_MRG,
        ST_P_PGMOFF,
        ST_P_VFY,
        ST_P_MRGOFF,
        ST_P_DECIDE,
        ST_E_SET,
        ST_E_WR,
        ST_E_HVON,
        ST_E_HVOFF,
        ST_E_ERSOFF
    } step_e;

    // Interlock filter applied to every register write, from bus or engine.
    function automatic ctl_t ctl_accept(ctl_t cur, ctl_t req);
        ctl_t nxt;
        if (req.pgm && req.erase) begin
            nxt = cur;
        end else begin
            nxt        = req;
            nxt.hven   = req.hven & (cur.pgm | cur.erase);
            nxt.margin = req.margin & ~nxt.hven & (cur.margin | cur.pgm);
        end
        return nxt;
    endfunction

    function automatic logic [3:0] div_of(logic [1:0] f);
        return 4'd1 << f;
    endfunction

endpackage

// File: rtl/nvm_pump_div.sv
module nvm_pump_div
    import nvm_pe_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       restart,
    input  logic [1:0] fdiv,
    output logic       tick
);
    localparam int CW = 3;

    logic [CW-1:0] cnt;
    logic [3:0]    lim;

    assign lim  = div_of(fdiv) - 4'd1;
    assign tick = ({1'b0, cnt} == lim);

    always_ff @(posedge clk) begin
        if (rst || restart || tick) cnt <= '0;
        else                        cnt <= cnt + 1'b1;
    end

    // R5: with a divide above one, two ticks are never adjacent
    a_r5_tick_gap: assert property (@(posedge clk) disable iff (rst)
        (tick && fdiv != 2'd0) |=> (!tick || fdiv == 2'd0));

endmodule

// File: rtl/nvm_ctl_reg.sv
module nvm_ctl_reg
    import nvm_pe_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       busy,
    input  logic       bus_we,
    input  logic [7:0] bus_wdata,
    input  logic       eng_we,
    input  ctl_t       eng_wdata,
    output ctl_t       ctl_q
);
    logic we;
    ctl_t req;

    // While a sequence runs only the engine owns the register.
    assign we  = busy ? eng_we : bus_we;
    assign req = busy ? eng_wdata : ctl_t'(bus_wdata);

    always_ff @(posedge clk) begin
        if (rst)     ctl_q <= '0;
        else if (we) ctl_q <= ctl_accept(ctl_q, req);
    end

    a_r2_pgm_erase_excl: assert property (@(posedge clk) disable iff (rst)
        !(ctl_q.pgm && ctl_q.erase));

    a_r3_hv_needs_mode: assert property (@(posedge clk) disable iff (rst)
        $rose(ctl_q.hven) |-> $past(ctl_q.pgm || ctl_q.erase));

    a_r4_margin_vs_hv: assert property (@(posedge clk) disable iff (rst)
        !(ctl_q.margin && ctl_q.hven));

    // R7: margin mode only opens on the back of a program setup
    a_r7_margin_after_prog: assert property (@(posedge clk) disable iff (rst)
        $rose(ctl_q.margin) |-> $past(ctl_q.pgm));

endmodule

// File: rtl/nvm_pe_engine.sv
module nvm_pe_engine
    import nvm_pe_pkg::*;
#(
    parameter int AW           = 14,
    parameter int TW           = 16,
    parameter int MAX_PULSES   = 30,
    parameter int MARGIN_EXTRA = 8,
    parameter int T_PROG       = 2000,
    parameter int T_HVTV       = 8,
    parameter int T_MTP        = 225,
    parameter int T_HVD        = 8,
    parameter int T_ERASE      = 60000,
    parameter int T_KILL       = 300,
    parameter int T_RCV        = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cmd_prog,
    input  logic          cmd_erase,
    input  logic [AW-1:0] cmd_addr,
    input  logic [1:0]    cmd_blk,
    input  logic [63:0]   page_data,
    input  ctl_t          ctl_q,
    input  logic          tick,
    input  logic [7:0]    arr_rdata,
    output logic          busy,
    output logic          eng_we,
    output ctl_t          eng_wdata,
    output logic          restart,
    output logic          arr_wr,
    output logic          arr_rd,
    output logic [AW-1:0] arr_addr,
    output logic [7:0]    arr_wdata,
    output logic          done,
    output logic          fail
);
    localparam int PCW = $clog2(MAX_PULSES + 1);
    localparam int RCW = $clog2(MARGIN_EXTRA + 2);

    step_e          step, nxt;
    logic           waiting;
    logic [TW-1:0]  wcnt, wlen;
    logic [2:0]     bidx;
    logic [RCW-1:0] rcnt;
    logic [AW-1:0]  addr_q;
    logic [1:0]     blk_q;
    logic [63:0]    data_q;
    logic           mism;
    logic [PCW-1:0] attempts;
    logic           is_wr;
    logic [7:0]     cur_byte;

    assign cur_byte = data_q[{bidx, 3'b000} +: 8];
    assign busy     = (step != ST_IDLE);

    // Per-step register request, wait length and successor.
    always_comb begin
        eng_wdata = ctl_q;
        wlen      = '0;
        is_wr     = 1'b0;
        nxt       = step;
        unique case (step)
            ST_P_PGM: begin
                is_wr = 1'b1; nxt = ST_P_LOAD;
                eng_wdata.hven = 1'b0; eng_wdata.margin = 1'b0;
                eng_wdata.erase = 1'b0; eng_wdata.pgm = 1'b1;
            end
            ST_P_HVON:   begin is_wr = 1'b1; eng_wdata.hven = 1'b1;   wlen = TW'(T_PROG);  nxt = ST_P_HVOFF;  end
            ST_P_HVOFF:  begin is_wr = 1'b1; eng_wdata.hven = 1'b0;   wlen = TW'(T_HVTV);  nxt = ST_P_MRG;    end
            ST_P_MRG:    begin is_wr = 1'b1; eng_wdata.margin = 1'b1; wlen = TW'(T_MTP);   nxt = ST_P_PGMOFF; end
            ST_P_PGMOFF: begin is_wr = 1'b1; eng_wdata.pgm = 1'b0;    wlen = TW'(T_HVD);   nxt = ST_P_VFY;    end
            ST_P_MRGOFF: begin is_wr = 1'b1; eng_wdata.margin = 1'b0;                      nxt = ST_P_DECIDE; end
            ST_E_SET: begin
                is_wr = 1'b1; nxt = ST_E_WR;
                eng_wdata.blk = blk_q; eng_wdata.hven = 1'b0; eng_wdata.margin = 1'b0;
                eng_wdata.erase = 1'b1; eng_wdata.pgm = 1'b0;
            end
            ST_E_HVON:   begin is_wr = 1'b1; eng_wdata.hven = 1'b1;  wlen = TW'(T_ERASE); nxt = ST_E_HVOFF;  end
            ST_E_HVOFF:  begin is_wr = 1'b1; eng_wdata.hven = 1'b0;  wlen = TW'(T_KILL);  nxt = ST_E_ERSOFF; end
            ST_E_ERSOFF: begin is_wr = 1'b1; eng_wdata.erase = 1'b0; wlen = TW'(T_RCV);   nxt = ST_IDLE;     end
            default: ;
        endcase
    end

    assign eng_we  = is_wr && !waiting;
    assign restart = eng_we;

    always_comb begin
        arr_wr    = 1'b0;
        arr_rd    = 1'b0;
        arr_addr  = {addr_q[AW-1:3], bidx};
        arr_wdata = cur_byte;
        unique case (step)
            ST_P_LOAD: arr_wr = 1'b1;
            ST_P_VFY:  arr_rd = 1'b1;
            ST_E_WR: begin
                arr_wr    = 1'b1;
                arr_addr  = addr_q;
                arr_wdata = 8'h00;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            step     <= ST_IDLE;
            waiting  <= 1'b0;
            wcnt     <= '0;
            bidx     <= '0;
            rcnt     <= '0;
            addr_q   <= '0;
            blk_q    <= '0;
            data_q   <= '0;
            mism     <= 1'b0;
            attempts <= '0;
            done     <= 1'b0;
            fail     <= 1'b0;
        end else begin
            done <= 1'b0;
            fail <= 1'b0;
            if (is_wr) begin
                if (!waiting) begin
                    if (step == ST_P_PGM) mism <= 1'b0;
                    if (wlen != '0) begin
                        waiting <= 1'b1;
                        wcnt    <= '0;
                    end else begin
                        step <= nxt;
                    end
                end else if (tick) begin
                    if (wcnt == wlen - 1'b1) begin
                        waiting <= 1'b0;
                        step    <= nxt;
                        if (nxt == ST_IDLE) done <= 1'b1;
                    end else begin
                        wcnt <= wcnt + 1'b1;
                    end
                end
            end else begin
                unique case (step)
                    ST_IDLE: begin
                        bidx <= '0;
                        rcnt <= '0;
                        if (cmd_prog) begin
                            addr_q   <= cmd_addr;
                            data_q   <= page_data;
                            attempts <= '0;
                            step     <= ST_P_PGM;
                        end else if (cmd_erase) begin
                            addr_q <= cmd_addr;
                            blk_q  <= cmd_blk;
                            step   <= ST_E_SET;
                        end
                    end
                    ST_P_LOAD: begin
                        bidx <= bidx + 1'b1;
                        if (bidx == 3'd7) step <= ST_P_HVON;
                    end
                    ST_P_VFY: begin
                        if (rcnt == RCW'(MARGIN_EXTRA)) begin
                            rcnt <= '0;
                            if (arr_rdata != cur_byte) mism <= 1'b1;
                            bidx <= bidx + 1'b1;
                            if (bidx == 3'd7) step <= ST_P_MRGOFF;
                        end else begin
                            rcnt <= rcnt + 1'b1;
                        end
                    end
                    ST_P_DECIDE: begin
                        if (!mism) begin
                            done <= 1'b1;
                            step <= ST_IDLE;
                        end else if (attempts == PCW'(MAX_PULSES - 1)) begin
                            done <= 1'b1;
                            fail <= 1'b1;
                            step <= ST_IDLE;
                        end else begin
                            attempts <= attempts + 1'b1;
                            step     <= ST_P_PGM;
                        end
                    end
                    ST_E_WR: step <= ST_E_HVON;
                    default: step <= ST_IDLE;
                endcase
            end
        end
    end

    a_r6_load_in_mode: assert property (@(posedge clk) disable iff (rst)
        arr_wr |-> ((ctl_q.pgm ^ ctl_q.erase) && !ctl_q.hven));

    a_r9_read_in_margin: assert property (@(posedge clk) disable iff (rst)
        arr_rd |-> (ctl_q.margin && !ctl_q.pgm && !ctl_q.hven));

    a_r11_attempt_bound: assert property (@(posedge clk) disable iff (rst)
        attempts < PCW'(MAX_PULSES));

    a_r10_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && !busy));

endmodule

// File: rtl/nvm_pe_ctrl.sv
module nvm_pe_ctrl
    import nvm_pe_pkg::*;
#(
    parameter int AW           = 14,
    parameter int TW           = 16,
    parameter int MAX_PULSES   = 30,
    parameter int MARGIN_EXTRA = 8,
    parameter int T_PROG       = 2000,
    parameter int T_HVTV       = 8,
    parameter int T_MTP        = 225,
    parameter int T_HVD        = 8,
    parameter int T_ERASE      = 60000,
    parameter int T_KILL       = 300,
    parameter int T_RCV        = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          reg_we,
    input  logic [7:0]    reg_wdata,
    output logic [7:0]    reg_rdata,
    input  logic          cmd_prog,
    input  logic          cmd_erase,
    input  logic [AW-1:0] cmd_addr,
    input  logic [1:0]    cmd_blk,
    input  logic [63:0]   page_data,
    output logic          busy,
    output logic          done,
    output logic          fail,
    output logic          pump_en,
    output logic          arr_wr,
    output logic          arr_rd,
    output logic [AW-1:0] arr_addr,
    output logic [7:0]    arr_wdata,
    input  logic [7:0]    arr_rdata,
    output logic          arr_prog,
    output logic          arr_erase,
    output logic          arr_hv,
    output logic          arr_margin,
    output logic [1:0]    arr_blk
);
    ctl_t ctl_q;
    ctl_t eng_wdata;
    logic eng_we;
    logic restart;
    logic tick;

    nvm_ctl_reg u_reg (
        .clk       (clk),
        .rst       (rst),
        .busy      (busy),
        .bus_we    (reg_we),
        .bus_wdata (reg_wdata),
        .eng_we    (eng_we),
        .eng_wdata (eng_wdata),
        .ctl_q     (ctl_q)
    );

    nvm_pump_div u_div (
        .clk     (clk),
        .rst     (rst),
        .restart (restart),
        .fdiv    (ctl_q.fdiv),
        .tick    (tick)
    );

    nvm_pe_engine #(
        .AW(AW), .TW(TW), .MAX_PULSES(MAX_PULSES), .MARGIN_EXTRA(MARGIN_EXTRA),
        .T_PROG(T_PROG), .T_HVTV(T_HVTV), .T_MTP(T_MTP), .T_HVD(T_HVD),
        .T_ERASE(T_ERASE), .T_KILL(T_KILL), .T_RCV(T_RCV)
    ) u_eng (
        .clk       (clk),
        .rst       (rst),
        .cmd_prog  (cmd_prog),
        .cmd_erase (cmd_erase),
        .cmd_addr  (cmd_addr),
        .cmd_blk   (cmd_blk),
        .page_data (page_data),
        .ctl_q     (ctl_q),
        .tick      (tick),
        .arr_rdata (arr_rdata),
        .busy      (busy),
        .eng_we    (eng_we),
        .eng_wdata (eng_wdata),
        .restart   (restart),
        .arr_wr    (arr_wr),
        .arr_rd    (arr_rd),
        .arr_addr  (arr_addr),
        .arr_wdata (arr_wdata),
        .done      (done),
        .fail      (fail)
    );

    assign reg_rdata  = ctl_q;
    assign pump_en    = tick;
    assign arr_prog   = ctl_q.pgm;
    assign arr_erase  = ctl_q.erase;
    assign arr_hv     = ctl_q.hven;
    assign arr_margin = ctl_q.margin;
    assign arr_blk    = ctl_q.blk;

endmodule

// File: tb/nvm_pe_ctrl_tb.sv
`timescale 1ns/1ps
module nvm_pe_ctrl_tb;
    localparam int AW = 8, MAXP = 4, MX = 8;
    localparam int TP = 3, TE = 5;

    logic clk = 1'b0, rst = 1'b1;
    logic reg_we = 1'b0; logic [7:0] reg_wdata = '0; logic [7:0] reg_rdata;
    logic cmd_prog = 1'b0, cmd_erase = 1'b0;
    logic [AW-1:0] cmd_addr = '0; logic [1:0] cmd_blk = '0; logic [63:0] page_data = '0;
    logic busy, done, fail, pump_en, arr_wr, arr_rd, arr_prog, arr_erase, arr_hv, arr_margin;
    logic [AW-1:0] arr_addr; logic [7:0] arr_wdata, arr_rdata; logic [1:0] arr_blk;

    always #2.5 clk = ~clk;

    nvm_pe_ctrl #(.AW(AW), .MAX_PULSES(MAXP), .MARGIN_EXTRA(MX), .T_PROG(TP), .T_HVTV(2),
        .T_MTP(2), .T_HVD(2), .T_ERASE(TE), .T_KILL(2), .T_RCV(2)) u_dut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .cmd_prog(cmd_prog), .cmd_erase(cmd_erase), .cmd_addr(cmd_addr), .cmd_blk(cmd_blk),
        .page_data(page_data), .busy(busy), .done(done), .fail(fail), .pump_en(pump_en),
        .arr_wr(arr_wr), .arr_rd(arr_rd), .arr_addr(arr_addr), .arr_wdata(arr_wdata),
        .arr_rdata(arr_rdata), .arr_prog(arr_prog), .arr_erase(arr_erase), .arr_hv(arr_hv),
        .arr_margin(arr_margin), .arr_blk(arr_blk));

    int n_chk = 0, n_fail = 0;

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Array model: a byte reads back its target once it has seen need_g pulses.
    logic [7:0] tgt [256];
    int pcount [256];
    int need_g = 1;
    assign arr_rdata = (pcount[arr_addr] >= need_g) ? tgt[arr_addr] : 8'hFF;

    // Monitors, sampled at the falling edge.
    int wr_n, pulse_n, hv_run, hv_len, rd_cyc, rd_grp, order_err, e_wr_n, e_rise;
    int ld_base, e_addr, e_blk;
    bit hv_prog, prev_rd, prev_margin, prev_erase;
    logic [AW-1:0] prev_raddr;
    int wr_addr [64]; int wr_data [64];

    task automatic clear_mon();
        wr_n = 0; pulse_n = 0; hv_run = 0; hv_len = 0; rd_cyc = 0; rd_grp = 0;
        order_err = 0; e_wr_n = 0; e_rise = 0; e_addr = -1; e_blk = -1;
        for (int i = 0; i < 256; i++) begin pcount[i] = 0; tgt[i] = 8'hFF; end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            if (arr_wr && arr_prog) begin
                if (wr_n < 64) begin wr_addr[wr_n] = int'(arr_addr); wr_data[wr_n] = int'(arr_wdata); end
                wr_n++;
                tgt[arr_addr] = arr_wdata;
                ld_base = int'(arr_addr) & ~7;
            end
            if (arr_wr && arr_erase) begin e_wr_n++; e_addr = int'(arr_addr); e_blk = int'(arr_blk); end
            if (arr_hv) begin
                hv_run++; hv_prog = arr_prog;
            end else if (hv_run != 0) begin
                hv_len = hv_run; pulse_n++; hv_run = 0;
                if (hv_prog) for (int i = 0; i < 8; i++) pcount[ld_base + i]++;
            end
            if (arr_margin && !prev_margin && !(arr_prog && !arr_hv)) order_err++;
            if (arr_rd && (!arr_margin || arr_prog)) order_err++;
            if (arr_rd) begin
                rd_cyc++;
                if (!prev_rd || arr_addr != prev_raddr) rd_grp++;
            end
            if (arr_erase && !prev_erase) e_rise++;
            prev_rd = arr_rd; prev_raddr = arr_addr; prev_margin = arr_margin; prev_erase = arr_erase;
        end
    end

    task automatic reg_write(input logic [7:0] v);
        @(negedge clk); reg_we = 1'b1; reg_wdata = v;
        @(negedge clk); reg_we = 1'b0;
    endtask

    task automatic wait_done(output bit f, output bit seen);
        seen = 0; f = 0;
        for (int i = 0; i < 5000 && !seen; i++) begin
            @(negedge clk);
            if (done) begin seen = 1; f = fail; end
        end
    endtask

    function automatic logic [7:0] exp_reg(logic [7:0] o, logic [7:0] w);
        logic hv, m;
        if (w[1] && w[0]) return o;
        hv = w[3] && (o[0] || o[1]);
        m  = w[2] && !hv && (o[2] || o[0]);
        return {w[7:4], hv, m, w[1:0]};
    endfunction

    task automatic set_state(input logic [7:0] s);
        reg_write(8'h00);
        if (s != 8'h00 && s != 8'h02) reg_write(8'h01);
        if (s != 8'h00 && s != 8'h01) reg_write(s);
    endtask

    task automatic run_prog(input logic [AW-1:0] a, input logic [63:0] d, input int need,
                            input int f, input bit xfail, input int xp, input string tag);
        bit fl, sn;
        int base;
        clear_mon(); need_g = need;
        reg_write(8'(f << 6));
        @(negedge clk); cmd_prog = 1'b1; cmd_addr = a; page_data = d;
        @(negedge clk); cmd_prog = 1'b0;
        wait_done(fl, sn);
        chk(sn, tag, "done seen", int'(sn), 1);
        chk(fl == xfail, tag, "fail flag", int'(fl), int'(xfail));
        chk(pulse_n == xp, tag, "pulse count", pulse_n, xp);
        chk(hv_len == TP * (1 << f) + 1, "R8", "program pulse cycles", hv_len, TP * (1 << f) + 1);
        chk(rd_cyc == 8 * (1 + MX) * xp, "R9", "margin read cycles", rd_cyc, 8 * (1 + MX) * xp);
        chk(rd_grp == 8 * xp, "R9", "read address groups", rd_grp, 8 * xp);
        chk(order_err == 0, "R7", "order violations", order_err, 0);
        chk(wr_n == 8 * xp, "R6", "page writes", wr_n, 8 * xp);
        base = int'(a) & ~7;
        for (int i = 0; i < 8; i++) begin
            chk(wr_addr[i] == base + i, "R6", "load address", wr_addr[i], base + i);
            chk(wr_data[i] == int'(d[8*i +: 8]), "R6", "load data", wr_data[i], int'(d[8*i +: 8]));
        end
        chk(reg_rdata == 8'(f << 6), tag, "register after program", int'(reg_rdata), f << 6);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL R10 watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        bit fl, sn;
        int cnt;
        logic [7:0] starts [5];
        clear_mon(); prev_rd = 0; prev_margin = 0; prev_erase = 0; prev_raddr = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk(reg_rdata == 8'h00, "R1", "register after reset", int'(reg_rdata), 0);
        chk(!busy && !done && !fail, "R1", "status after reset", int'({busy, done, fail}), 0);

        // R2 R3 R4: sweep every write from several reachable states
        starts = '{8'h00, 8'h01, 8'h02, 8'h05, 8'h09};
        foreach (starts[k]) begin
            for (int w = 0; w < 256; w++) begin
                logic [7:0] e;
                string tg;
                set_state(starts[k]);
                reg_write(8'(w));
                e = exp_reg(starts[k], 8'(w));
                tg = (w[1] && w[0]) ? "R2" : (w[3] ? "R3" : (w[2] ? "R4" : "R2"));
                chk(reg_rdata == e, tg, "register after write", int'(reg_rdata), int'(e));
            end
        end
        reg_write(8'h00);

        // R5: pump enable rate for each divide select
        for (int f = 0; f < 4; f++) begin
            reg_write(8'(f << 6));
            cnt = 0;
            for (int i = 0; i < 64; i++) begin @(negedge clk); if (pump_en) cnt++; end
            chk(cnt == (64 >> f), "R5", "pump ticks in 64 cycles", cnt, 64 >> f);
        end

        // R6..R10: one-pulse program, unaligned address, two divides
        run_prog(8'h35, 64'h0123_4567_89AB_CDEF, 1, 1, 1'b0, 1, "R10");
        run_prog(8'h80, 64'h1122_3344_5566_7700, 1, 0, 1'b0, 1, "R10");
        // R10: retries until the data verifies
        run_prog(8'h48, 64'hA5A5_5A5A_0F0F_F0F0, 3, 2, 1'b0, 3, "R10");
        // R11: gives up after MAX_PULSES
        run_prog(8'h10, 64'h0102_0304_0506_0708, 10, 0, 1'b1, MAXP, "R11");

        // R12: erase of an eight-row block with divide 4
        clear_mon();
        reg_write(8'h80);
        @(negedge clk); cmd_erase = 1'b1; cmd_addr = 8'h47; cmd_blk = 2'b10;
        @(negedge clk); cmd_erase = 1'b0;
        wait_done(fl, sn);
        chk(sn && !fl, "R12", "erase done without fail", int'(fl), 0);
        chk(e_wr_n == 1, "R12", "erase array writes", e_wr_n, 1);
        chk(e_addr == 8'h47, "R12", "erase write address", e_addr, 8'h47);
        chk(e_blk == 2, "R12", "block code at write", e_blk, 2);
        chk(pulse_n == 1, "R12", "erase pulses", pulse_n, 1);
        chk(hv_len == TE * 4 + 1, "R12", "erase pulse cycles", hv_len, TE * 4 + 1);
        chk(reg_rdata == 8'hA0, "R12", "register after erase", int'(reg_rdata), 8'hA0);

        // R13: bus write and erase command during a program are ignored
        clear_mon(); need_g = 1;
        reg_write(8'h40);
        @(negedge clk); cmd_prog = 1'b1; cmd_addr = 8'h20; page_data = 64'h1111_2222_3333_4444;
        @(negedge clk); cmd_prog = 1'b0;
        repeat (4) @(negedge clk);
        reg_write(8'hC0);
        @(negedge clk); cmd_erase = 1'b1; cmd_addr = 8'h00;
        @(negedge clk); cmd_erase = 1'b0;
        wait_done(fl, sn);
        chk(sn && !fl, "R13", "program unaffected", int'(fl), 0);
        chk(reg_rdata == 8'h40, "R13", "divide select kept", int'(reg_rdata), 8'h40);
        chk(e_rise == 0, "R13", "no erase started", e_rise, 0);
        chk(hv_len == TP * 2 + 1, "R13", "pulse length with kept divide", hv_len, TP * 2 + 1);
        repeat (10) @(negedge clk);
        chk(!busy && e_rise == 0, "R13", "idle with no pending erase", int'(busy), 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule